// File: doc/BRIEF.md
# Genlock Subcarrier Frame Serializer

This block sends the state of a colour-subcarrier oscillator to a downstream video encoder over one serial pin. The 23-bit frequency control word sets the subcarrier frequency as word / 2^23 times the serial clock. The serial clock runs at twice the pixel rate. Two flags travel in the same frame:

- A line-sequence bit. In PAL mode it is 1 on a normal (R-Y) line and 0 on an inverted one. In NTSC mode it is always 1.
- An active-low subcarrier reset bit.

A one-cycle request strobe starts a frame. At the accepting clock edge the word and both flags are copied into a shadow register. The input ports may change freely while the frame is being sent. Every frame lasts 128 serial clocks and has the following fixed layout, by frame position:

| Positions | Content |
|---|---|
| 0 to 15 | Low leading gap |
| 16 | One-clock start bit |
| 17 to 62 | Increment, bit 22 first, each bit held for two clocks |
| 63 to 64 | Sequence bit |
| 65 to 66 | Reset bit |
| 67 to 127 | Low trailing gap |

The pin is registered, so it shows position p during the cycle that follows clock edge E0+p+1, where E0 is the accepting edge.

Top module: `genlock_rtc_tx`

## Requirements
- R1: While reset is held and after its release with no request, `rtc_out` and `busy` are 0.
- R2: A high `frame_req` at an edge where `busy` is 0, or at the last clock of a frame, starts a frame at that edge (E0) and captures `fcw_in`, `sc_reset`, `pal_mode` and `line_inv`. Frame position p appears on `rtc_out` after edge E0+p+1.
- R3: `busy` is 1 after edges E0 through E0+127 and 0 after E0+128 unless a new frame was accepted there. A request held at the last frame clock starts the next frame with no gap.
- R4: Positions 0 to 15 and 67 to 127 are driven low.
- R5: Position 16 is the start bit, high for exactly one clock.
- R6: Positions 17 to 62 carry the captured word MSB first: position p carries bit 22-(p-17)/2, so each bit lasts two clocks.
- R7: Positions 63 and 64 carry the sequence bit. It equals NOT `line_inv` when `pal_mode`=1 and is 1 when `pal_mode`=0.
- R8: Positions 65 and 66 carry NOT `sc_reset` (active-low reset bit).
- R9: Input changes and requests made while a frame is in progress, except at its last clock, have no effect on that frame's bits, its length or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_req | input | 1 | Request to start a frame |
| fcw_in | input | 23 | Subcarrier frequency control word |
| sc_reset | input | 1 | Subcarrier reset request, active high at the port |
| pal_mode | input | 1 | 1 selects PAL sequence rules, 0 NTSC |
| line_inv | input | 1 | 1 when the current (R-Y) line is inverted |
| rtc_out | output | 1 | Serial genlock frame |
| busy | output | 1 | Frame in progress |

## Verification
On every cycle, the assertions check four things:

- The position counter steps by one inside a frame and rests at zero when idle.
- A frame cannot be cut short.
- The shadow stays frozen between captures.
- Gap positions give a low pin and the start position gives a high pin.

The order of the increment bits, the PAL and NTSC sequence rules, the reset polarity, chained frames and immunity to mid-frame input changes are shown only by the bench scenarios. The bench deserializes each frame and compares every position against values it computes from the captured inputs.

// File: rtl/rtc_tx_pkg.sv
// Shared types for the genlock frame serializer.
// Assumes: one field tag per frame position is enough for the bit selector.
package rtc_tx_pkg;
    typedef enum logic [2:0] {
        FLD_GAP   = 3'd0,
        FLD_START = 3'd1,
        FLD_INC   = 3'd2,
        FLD_SEQ   = 3'd3,
        FLD_RST   = 3'd4
    } fld_e;
endpackage

// File: rtl/rtc_frame_timer.sv
// Frame position counter and position decoder.
// Accepts a request when idle or on the last frame clock, counts FRAME_CLKS
// positions and tags each position with its field and, in the increment field,
// the word bit index. Assumes the layout fits inside FRAME_CLKS.
module rtc_frame_timer
    import rtc_tx_pkg::*;
#(
    parameter int FRAME_CLKS = 128,
    parameter int LEAD_CLKS  = 16,
    parameter int WORD_W     = 23,
    parameter int BIT_CLKS   = 2,
    localparam int CW        = $clog2(FRAME_CLKS),
    localparam int IW        = $clog2(WORD_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    output logic          load,
    output logic          busy,
    output fld_e          fld,
    output logic [IW-1:0] bit_idx
);
    localparam int INC_BEG = LEAD_CLKS + 1;
    localparam int INC_END = INC_BEG + WORD_W * BIT_CLKS;
    localparam int SEQ_END = INC_END + BIT_CLKS;
    localparam int RST_END = SEQ_END + BIT_CLKS;

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          last;

    assign last = busy_q && (cnt_q == CW'(FRAME_CLKS - 1));
    assign load = req && (!busy_q || last);
    assign busy = busy_q;

    // Advance the frame position, restart on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (last) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Map the current position onto a field and a word bit index.
    always_comb begin
        int p;
        p       = int'(cnt_q);
        fld     = FLD_GAP;
        bit_idx = '0;
        if (busy_q) begin
            if (p == LEAD_CLKS) begin
                fld = FLD_START;
            end else if (p >= INC_BEG && p < INC_END) begin
                fld     = FLD_INC;
                bit_idx = IW'(WORD_W - 1 - (p - INC_BEG) / BIT_CLKS);
            end else if (p >= INC_END && p < SEQ_END) begin
                fld = FLD_SEQ;
            end else if (p >= SEQ_END && p < RST_END) begin
                fld = FLD_RST;
            end
        end
    end

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_idle_cnt_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (cnt_q == '0));
    p_no_cut_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last) |=> busy_q);
endmodule

// File: rtl/rtc_shadow.sv
// Captures the word and both status bits at frame start.
// The reset bit is stored already in its active-low line form.
// Assumes load is a single-cycle strobe from the timer.
module rtc_shadow #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              sc_reset,
    input  logic              pal_mode,
    input  logic              line_inv,
    output logic [WORD_W-1:0] word_q,
    output logic              seq_q,
    output logic              rstb_q
);
    // Hold the frame contents until the next accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            seq_q  <= 1'b1;
            rstb_q <= 1'b1;
        end else if (load) begin
            word_q <= word_in;
            seq_q  <= pal_mode ? ~line_inv : 1'b1;
            rstb_q <= ~sc_reset;
        end
    end
endmodule

// File: rtl/rtc_bit_mux.sv
// Selects the line level for the tagged position and registers it onto the pin.
// Assumes the field tag and bit index refer to the same position.
module rtc_bit_mux
    import rtc_tx_pkg::*;
#(
    parameter int WORD_W = 23,
    localparam int IW    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fld_e              fld,
    input  logic [IW-1:0]     bit_idx,
    input  logic [WORD_W-1:0] word_q,
    input  logic              seq_q,
    input  logic              rstb_q,
    output logic              rtc_q
);
    logic nxt;

    // Choose the level for this position.
    always_comb begin
        unique case (fld)
            FLD_START: nxt = 1'b1;
            FLD_INC:   nxt = word_q[bit_idx];
            FLD_SEQ:   nxt = seq_q;
            FLD_RST:   nxt = rstb_q;
            default:   nxt = 1'b0;
        endcase
    end

    // Register the pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) rtc_q <= 1'b0;
        else        rtc_q <= nxt;
    end

    p_gap_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fld == FLD_GAP) |=> !rtc_q);
    p_start_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fld == FLD_START) |=> rtc_q);
endmodule

// File: rtl/genlock_rtc_tx.sv
// Genlock serial frame transmitter: timer, shadow capture and bit selector.
// Assumes clk is the serial clock at twice the pixel rate.
module genlock_rtc_tx
    import rtc_tx_pkg::*;
#(
    parameter int FRAME_CLKS = 128,
    parameter int LEAD_CLKS  = 16,
    parameter int WORD_W     = 23,
    parameter int BIT_CLKS   = 2,
    localparam int IW        = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_req,
    input  logic [WORD_W-1:0] fcw_in,
    input  logic              sc_reset,
    input  logic              pal_mode,
    input  logic              line_inv,
    output logic              rtc_out,
    output logic              busy
);
    logic              load;
    fld_e              fld;
    logic [IW-1:0]     bit_idx;
    logic [WORD_W-1:0] word_q;
    logic              seq_q;
    logic              rstb_q;

    rtc_frame_timer #(
        .FRAME_CLKS(FRAME_CLKS), .LEAD_CLKS(LEAD_CLKS),
        .WORD_W(WORD_W), .BIT_CLKS(BIT_CLKS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .req(frame_req), .load(load),
        .busy(busy), .fld(fld), .bit_idx(bit_idx)
    );

    rtc_shadow #(.WORD_W(WORD_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load), .word_in(fcw_in),
        .sc_reset(sc_reset), .pal_mode(pal_mode), .line_inv(line_inv),
        .word_q(word_q), .seq_q(seq_q), .rstb_q(rstb_q)
    );

    rtc_bit_mux #(.WORD_W(WORD_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .fld(fld), .bit_idx(bit_idx),
        .word_q(word_q), .seq_q(seq_q), .rstb_q(rstb_q), .rtc_q(rtc_out)
    );

    p_shadow_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> ($stable(word_q) && $stable(seq_q) && $stable(rstb_q)));
endmodule

// File: tb/genlock_rtc_tx_tb.sv
// Deserializes frames and compares every position with computed values.
module genlock_rtc_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_req = 1'b0;
    logic [22:0] fcw_in = '0;
    logic        sc_reset = 1'b0;
    logic        pal_mode = 1'b0;
    logic        line_inv = 1'b0;
    logic        rtc_out;
    logic        busy;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    genlock_rtc_tx u_dut (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .fcw_in(fcw_in),
        .sc_reset(sc_reset), .pal_mode(pal_mode), .line_inv(line_inv),
        .rtc_out(rtc_out), .busy(busy)
    );

    function automatic logic exp_bit(int p, logic [22:0] w, logic r, logic pal, logic inv);
        if (p == 16)            return 1'b1;
        if (p >= 17 && p < 63)  return w[22 - (p - 17) / 2];
        if (p == 63 || p == 64) return pal ? ~inv : 1'b1;
        if (p == 65 || p == 66) return ~r;
        return 1'b0;
    endfunction

    function automatic string tag_of(int p);
        if (p == 16)            return "R5";
        if (p >= 17 && p < 63)  return "R6";
        if (p == 63 || p == 64) return "R7";
        if (p == 65 || p == 66) return "R8";
        return "R4";
    endfunction

    task automatic cmp(string req, logic act, logic exp, int p);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s pos %0d: actual %b expected %b", req, p, act, exp);
        end
    endtask

    // Called just after an accepting edge E0. With mid set, inputs change and
    // a stray request is made during the frame (R9). With chain set, the next
    // frame's inputs and request are applied at the last clock (R3).
    task automatic check_frame(logic [22:0] w, logic r, logic pal, logic inv,
                               bit mid, bit chain,
                               logic [22:0] nw, logic nr, logic npal, logic ninv);
        cmp("R2", busy, 1'b1, -1);
        for (int p = 0; p < 128; p++) begin
            @(posedge clk); #1;
            cmp(mid ? "R9" : tag_of(p), rtc_out, exp_bit(p, w, r, pal, inv), p);
            cmp("R3", busy, (p < 127) ? 1'b1 : chain, p);
            if (mid && p == 30) begin
                fcw_in = ~w; sc_reset = ~r; pal_mode = ~pal; line_inv = ~inv;
                frame_req = 1'b1;
            end
            if (mid && p == 31) frame_req = 1'b0;
            if (chain && p == 126) begin
                fcw_in = nw; sc_reset = nr; pal_mode = npal; line_inv = ninv;
                frame_req = 1'b1;
            end
            if (chain && p == 127) frame_req = 1'b0;
        end
    endtask

    task automatic start_and_check(logic [22:0] w, logic r, logic pal, logic inv, bit mid);
        fcw_in = w; sc_reset = r; pal_mode = pal; line_inv = inv; frame_req = 1'b1;
        @(posedge clk); #1;
        frame_req = 1'b0;
        check_frame(w, r, pal, inv, mid, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        cmp("R3", busy, 1'b0, 128);
        cmp("R4", rtc_out, 1'b0, 128);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs during reset and after release with no request.
        repeat (3) @(posedge clk);
        #1;
        cmp("R1", rtc_out, 1'b0, -1);
        cmp("R1", busy, 1'b0, -1);
        rst_n = 1'b1;
        fcw_in = 23'h7FFFFF; sc_reset = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        cmp("R1", rtc_out, 1'b0, -1);
        cmp("R1", busy, 1'b0, -1);

        // R6 R7 R8: patterns crossed with every flag combination.
        for (int f = 0; f < 8; f++) begin
            start_and_check(23'h000000, f[0], f[1], f[2], 1'b0);
            start_and_check(23'h7FFFFF, f[0], f[1], f[2], 1'b0);
            start_and_check(23'h555555, f[0], f[1], f[2], 1'b0);
            start_and_check(23'h2AAAAA, f[0], f[1], f[2], 1'b0);
        end
        // R6: walking one across every bit position.
        for (int b = 0; b < 23; b++)
            start_and_check(23'(1) << b, 1'b0, 1'b1, 1'b0, 1'b0);

        // R9: changes and a stray request mid-frame.
        start_and_check(23'h1234AB, 1'b1, 1'b1, 1'b0, 1'b1);
        start_and_check(23'h6C0F31, 1'b0, 1'b0, 1'b1, 1'b1);

        // R3: back-to-back frames with no gap.
        fcw_in = 23'h0F0F0F; sc_reset = 1'b0; pal_mode = 1'b1; line_inv = 1'b1;
        frame_req = 1'b1;
        @(posedge clk); #1;
        frame_req = 1'b0;
        check_frame(23'h0F0F0F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                    23'h70F0F0, 1'b1, 1'b0, 1'b1);
        check_frame(23'h70F0F0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
                    '0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        cmp("R3", busy, 1'b0, 128);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule